// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block steps a clock synthesiser from one output rate to another. A client presents a request on a valid/ready channel. The request is one of four things: a rate index, a power-up command, a power-down command, or a reserved code. The sequencer looks up divider settings for the index in a parameter-computed table. It compares them with the values it last wrote and then drives the synthesiser's control and divider registers through a one-cycle write port.

When only the output post-divider differs, the sequencer rewrites that field alone and finishes. In every other case it runs the full relock procedure:

1. select the PLL's own lock detector as the lock source;
2. route the reference around the PLL (bypass);
3. hold the PLL in reset;
4. program the dividers;
5. keep reset low for a timed interval, measured in microsecond ticks;
6. release reset and poll the lock input under a timeout;
7. remove the bypass.

A one-cycle done pulse ends every request. The error flag is valid only in that same cycle.

The request channel applies back-pressure by lowering `req_ready` for the whole time a request is being served. A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. Anything presented while `req_ready` is low is dropped, not queued. The write port and the status pins have no handshake.

Top module: `pll_reprog_seq`

## Requirements
- R1: Register map and table. Address 0 is general control, address 1 is divider A and address 2 is divider B.
  - Divider A holds the main divider m in bits 21:12, the pre-divider p in bits 9:4 and the post-divider s in bits 2:0. A full write of divider A leaves every other bit 0.
  - Divider B holds the fractional value k in bits 15:0.
  - Table entry i has m=250+50*(i/2), p=3 when (i/2) is even and 63 otherwise, s=2 for odd i and 1 for even i, and k=4096*(i/2).
- R2: In general control, bit 29 selects the lock source, bit 4 is bypass, bit 9 is an active-low reset and bit 11 is output enable. Every write to general control changes only the bit named for that step. All control values start at 0 after reset.
- R3: If the table's m, p and k for a rate request equal the current register contents, the only write is divider A with its s field replaced. No lock wait follows, and the done pulse has the error flag low.
- R4: Otherwise the writes come in this exact order: general control with bit 29 set, then with bit 4 set, then with bit 9 cleared, then divider A, then divider B.
- R5: After the last divider write, reset stays low for at least H microsecond ticks. H is the larger of MIN_HOLD (default 2) and ceil(p/REF_MHZ)+1, with REF_MHZ defaulting to 24.
- R6: Reset is then set again, and the sequencer waits for the lock input. Once lock is seen, bit 4 is cleared and the request finishes without error.
- R7: If lock does not arrive within TIMEOUT_US ticks (default 10000) of the reset release, the request finishes with the error flag set and bypass stays set.
- R8: An index outside the table, or request code 3, finishes with the error flag set and makes no register write.
- R9: Request code 1 sets bit 9 and waits for lock under the same timeout. Request code 2 clears bit 9 and finishes without waiting. Code 0 is a rate request.
- R10: `req_ready` is low while busy, and a request presented then has no effect. The done pulse lasts one cycle, and the error flag is never high outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 rate, 1 power-up, 2 power-down, 3 reserved |
| req_idx | input | IDX_W | Rate table index |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request failed; valid with done |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 2 | Register address |
| wr_data | output | 32 | Register write value |
| pll_lock | input | 1 | Lock status from the PLL |

## Verification
A wrong state or a lost shadow value shows up at the write port straight away. It appears as a write out of order, a bit changed outside its own step, or a fast path taken when a full relock was due. The write log of a single request exposes it. A hold or timeout counter that runs short or long shows up as a tick distance that falls outside its window. That distance is the gap between the divider write and the reset release, or between the release and the done pulse, and it is visible within tens of ticks. A broken accept or finish path shows up as a missing done pulse, a done pulse of two cycles, or writes that follow a request which should have been dropped.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int GEN_LSEL = 29;
  localparam int GEN_CKEN = 11;
  localparam int GEN_RSTN = 9;
  localparam int GEN_BYP  = 4;

  localparam logic [1:0] ADDR_GEN  = 2'd0;
  localparam logic [1:0] ADDR_DIVA = 2'd1;
  localparam logic [1:0] ADDR_DIVB = 2'd2;

  localparam logic [1:0] OP_RATE = 2'd0;
  localparam logic [1:0] OP_UP   = 2'd1;
  localparam logic [1:0] OP_DOWN = 2'd2;

  typedef struct packed {
    logic [9:0]  m;
    logic [5:0]  p;
    logic [2:0]  s;
    logic [15:0] k;
  } pll_set_t;

  typedef enum logic [3:0] {
    S_IDLE, S_EVAL, S_LSEL, S_BYP, S_RLO, S_DIVA, S_DIVB,
    S_HOLD, S_REL, S_LOCK, S_UNBYP, S_FIN
  } seq_state_t;

  function automatic pll_set_t rate_entry(input int i);
    pll_set_t e;
    int j;
    j   = i / 2;
    e.m = 10'(250 + 50 * j);
    e.p = (j % 2 == 0) ? 6'd3 : 6'd63;
    e.s = (i % 2 == 1) ? 3'd2 : 3'd1;
    e.k = 16'(4096 * j);
    return e;
  endfunction

  function automatic int unsigned hold_ticks(input int unsigned p,
                                             input int unsigned ref_mhz,
                                             input int unsigned min_hold);
    int unsigned r;
    r = (p + ref_mhz - 1) / ref_mhz + 1;
    return (r > min_hold) ? r : min_hold;
  endfunction

endpackage

// File: rtl/pll_rate_rom.sv
module pll_rate_rom
  import pll_seq_pkg::*;
#(
  parameter int NUM_RATES = 4,
  parameter int IDX_W     = $clog2(NUM_RATES) + 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic             hit,
  output pll_set_t         set
);
  localparam int SEL_W = $clog2(NUM_RATES);

  pll_set_t tbl [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_ent
    assign tbl[g] = rate_entry(g);
  end

  assign hit = (32'(idx) < NUM_RATES);
  assign set = hit ? tbl[idx[SEL_W-1:0]] : '0;
endmodule

// File: rtl/pll_tick_timer.sv
module pll_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clr)            count <= '0;
    else if (en && tick && count != '1) count <= count + 1'b1;
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int NUM_RATES  = 4,
  parameter int IDX_W      = $clog2(NUM_RATES) + 1,
  parameter bit FRACTIONAL = 1'b1,
  parameter int REF_MHZ    = 24,
  parameter int MIN_HOLD   = 2,
  parameter int TIMEOUT_US = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             wr_en,
  output logic [1:0]       wr_addr,
  output logic [31:0]      wr_data,
  input  logic             pll_lock
);
  localparam int CNT_W = $clog2(TIMEOUT_US + 1) + 2;

  seq_state_t state, state_n;
  logic [1:0]       op_q;
  logic [IDX_W-1:0] idx_q;
  logic             err_q, err_set;
  logic [31:0]      sh_gen, sh_diva, sh_divb;
  logic             hit, k_same, same_mpk;
  pll_set_t         ent;
  logic             cnt_clr, cnt_en;
  logic [CNT_W-1:0] cnt, need;

  pll_rate_rom #(.NUM_RATES(NUM_RATES), .IDX_W(IDX_W)) u_rom (
    .idx(idx_q), .hit(hit), .set(ent)
  );

  pll_tick_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en),
    .tick(tick_us), .count(cnt)
  );

  if (FRACTIONAL) begin : g_frac
    assign k_same = (ent.k == sh_divb[15:0]);
  end else begin : g_int
    assign k_same = 1'b1;
  end

  assign same_mpk = (ent.m == sh_diva[21:12]) && (ent.p == sh_diva[9:4]) && k_same;
  assign need     = CNT_W'(hold_ticks({26'd0, ent.p}, REF_MHZ, MIN_HOLD));

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign err       = done && err_q;

  always_comb begin
    state_n = state;
    wr_en   = 1'b0;
    wr_addr = ADDR_GEN;
    wr_data = '0;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    err_set = 1'b0;
    unique case (state)
      S_IDLE: if (req_valid) state_n = S_EVAL;
      S_EVAL: begin
        if (op_q == OP_DOWN) begin
          wr_en = 1'b1; wr_data = sh_gen & ~(32'd1 << GEN_RSTN); state_n = S_FIN;
        end else if (op_q == OP_UP) begin
          wr_en = 1'b1; wr_data = sh_gen | (32'd1 << GEN_RSTN);
          cnt_clr = 1'b1; state_n = S_LOCK;
        end else if (op_q != OP_RATE || !hit) begin
          err_set = 1'b1; state_n = S_FIN;
        end else if (same_mpk) begin
          wr_en = 1'b1; wr_addr = ADDR_DIVA;
          wr_data = {sh_diva[31:3], ent.s}; state_n = S_FIN;
        end else begin
          state_n = S_LSEL;
        end
      end
      S_LSEL: begin
        wr_en = 1'b1; wr_data = sh_gen | (32'd1 << GEN_LSEL); state_n = S_BYP;
      end
      S_BYP: begin
        wr_en = 1'b1; wr_data = sh_gen | (32'd1 << GEN_BYP); state_n = S_RLO;
      end
      S_RLO: begin
        wr_en = 1'b1; wr_data = sh_gen & ~(32'd1 << GEN_RSTN); state_n = S_DIVA;
      end
      S_DIVA: begin
        wr_en = 1'b1; wr_addr = ADDR_DIVA; cnt_clr = 1'b1;
        wr_data = {10'd0, ent.m, 2'd0, ent.p, 1'b0, ent.s};
        state_n = FRACTIONAL ? S_DIVB : S_HOLD;
      end
      S_DIVB: begin
        wr_en = 1'b1; wr_addr = ADDR_DIVB; cnt_clr = 1'b1;
        wr_data = {16'd0, ent.k}; state_n = S_HOLD;
      end
      S_HOLD: begin
        cnt_en = 1'b1;
        if (cnt >= need) state_n = S_REL;
      end
      S_REL: begin
        wr_en = 1'b1; wr_data = sh_gen | (32'd1 << GEN_RSTN);
        cnt_clr = 1'b1; state_n = S_LOCK;
      end
      S_LOCK: begin
        cnt_en = 1'b1;
        if (pll_lock) state_n = (op_q == OP_RATE) ? S_UNBYP : S_FIN;
        else if (cnt >= CNT_W'(TIMEOUT_US)) begin
          err_set = 1'b1; state_n = S_FIN;
        end
      end
      S_UNBYP: begin
        wr_en = 1'b1; wr_data = sh_gen & ~(32'd1 << GEN_BYP); state_n = S_FIN;
      end
      S_FIN:   state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_RATE;
      idx_q   <= '0;
      err_q   <= 1'b0;
      sh_gen  <= '0;
      sh_diva <= '0;
      sh_divb <= '0;
    end else begin
      state <= state_n;
      if (state == S_IDLE && req_valid) begin
        op_q  <= req_op;
        idx_q <= req_idx;
        err_q <= 1'b0;
      end
      if (err_set) err_q <= 1'b1;
      if (wr_en) begin
        unique case (wr_addr)
          ADDR_GEN:  sh_gen  <= wr_data;
          ADDR_DIVA: sh_diva <= wr_data;
          default:   sh_divb <= wr_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
  import pll_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        pll_lock
);
  logic [31:0] last_gen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_gen <= '0;
    else if (wr_en && wr_addr == ADDR_GEN) last_gen <= wr_data;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  err_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  // R8
  write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R4
  frac_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_DIVB) |-> !last_gen[GEN_RSTN]);

  // R6
  unbypass_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_GEN && last_gen[GEN_BYP] && !wr_data[GEN_BYP])
      |-> $past(pll_lock));
endmodule

bind pll_reprog_seq pll_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .err(err), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pll_lock(pll_lock)
);

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
  localparam int TO  = 40;
  localparam int LDLY = 6;
  localparam logic [31:0] LSEL = 32'h2000_0000;
  localparam logic [31:0] RSTB = 32'h0000_0200;
  localparam logic [31:0] BYPB = 32'h0000_0010;

  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0;
  logic req_valid = 1'b0, req_ready, busy, done, err, wr_en, pll_lock;
  logic [1:0] req_op = 2'd0, wr_addr;
  logic [2:0] req_idx = 3'd0;
  logic [31:0] wr_data;

  int checks = 0, errors = 0, cyc = 0, tcount = 0, nlog = 0, done_t = 0;
  logic [1:0]  la [64];
  logic [31:0] ld [64];
  int          lt [64];
  logic [31:0] cur_gen = '0;
  bit no_lock = 1'b0, lock_r = 1'b0;
  int lock_cnt = -1;

  always #2.5 clk = ~clk;

  pll_reprog_seq #(.TIMEOUT_US(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_idx(req_idx), .busy(busy),
    .done(done), .err(err), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pll_lock(pll_lock)
  );

  assign pll_lock = lock_r;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_us <= (cyc % 4 == 0);
  end

  always @(posedge clk) begin
    tcount <= tcount + (tick_us ? 1 : 0);
    if (done) done_t <= tcount;
    if (wr_en && nlog < 64) begin
      la[nlog] <= wr_addr; ld[nlog] <= wr_data; lt[nlog] <= tcount;
      nlog <= nlog + 1;
    end
    if (wr_en && wr_addr == 2'd0) begin
      if (wr_data[9] && !no_lock) lock_cnt <= LDLY;
      else if (!wr_data[9]) begin lock_cnt <= -1; lock_r <= 1'b0; end
    end else if (lock_cnt > 0) lock_cnt <= lock_cnt - 1;
    else if (lock_cnt == 0) begin lock_r <= 1'b1; lock_cnt <= -1; end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_diva(input int i);
    int j = i / 2;
    logic [9:0] m = 10'(250 + 50 * j);
    logic [5:0] p = (j % 2 == 0) ? 6'd3 : 6'd63;
    logic [2:0] s = (i % 2 == 1) ? 3'd2 : 3'd1;
    return {10'd0, m, 2'd0, p, 1'b0, s};
  endfunction

  function automatic int exp_hold(input int i);
    int p = ((i / 2) % 2 == 0) ? 3 : 63;
    int r = (p + 23) / 24 + 1;
    return (r > 2) ? r : 2;
  endfunction

  task automatic request(input logic [1:0] op, input logic [2:0] idx,
                         output int base, output int nw, output logic e);
    int wd = 0;
    base = nlog;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_idx = idx;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && wd < 5000) begin @(negedge clk); wd++; end
    chk(done, "R10", "done seen", done, 1);
    e = err;
    @(negedge clk);
    chk(!done && !err, "R10", "done one cycle", done, 0);
    nw = nlog - base;
    for (int q = base; q < nlog; q++) if (la[q] == 2'd0) cur_gen = ld[q];
  endtask

  task automatic check_full(input int b, input int nw, input int idx,
                            input logic [31:0] g0, input bit locks);
    logic [31:0] g1 = g0 | LSEL, g2 = g1 | BYPB, g3 = g2 & ~RSTB;
    logic [31:0] g4 = g3 | RSTB;
    int h;
    chk(nw == (locks ? 7 : 6), "R4", "write count", nw, locks ? 7 : 6);
    chk(la[b] == 0 && ld[b] == g1, "R4", "lock-source write", ld[b], g1);
    chk(la[b+1] == 0 && ld[b+1] == g2, "R2", "bypass write", ld[b+1], g2);
    chk(la[b+2] == 0 && ld[b+2] == g3, "R4", "reset-low write", ld[b+2], g3);
    chk(la[b+3] == 1 && ld[b+3] == exp_diva(idx), "R1", "divider A", ld[b+3], exp_diva(idx));
    chk(la[b+4] == 2 && ld[b+4] == 32'(4096 * (idx / 2)), "R1", "divider B k",
        ld[b+4], 4096 * (idx / 2));
    chk(la[b+5] == 0 && ld[b+5] == g4, "R6", "reset release", ld[b+5], g4);
    h = lt[b+5] - lt[b+4];
    chk(h >= exp_hold(idx) && h <= exp_hold(idx) + 2, "R5", "hold ticks", h, exp_hold(idx));
    if (locks)
      chk(la[b+6] == 0 && ld[b+6] == (g4 & ~BYPB), "R6", "bypass clear",
          ld[b+6], g4 & ~BYPB);
  endtask

  task automatic t_reset;
    chk(req_ready && !busy && !done && !err && !wr_en, "R2", "idle after reset",
        {req_ready, busy, done, err, wr_en}, 5'b10000);
  endtask

  task automatic t_power_up;
    int b, n; logic e;
    request(2'd1, 3'd0, b, n, e);
    chk(n == 1 && ld[b] == RSTB, "R9", "power-up write", ld[b], RSTB);
    chk(!e, "R9", "power-up err", e, 0);
  endtask

  task automatic t_full(input int idx);
    int b, n; logic e; logic [31:0] g0 = cur_gen;
    request(2'd0, 3'(idx), b, n, e);
    check_full(b, n, idx, g0, 1'b1);
    chk(!e, "R6", "full path err", e, 0);
  endtask

  task automatic t_fast;
    int b, n; logic e;
    request(2'd0, 3'd0, b, n, e);
    chk(n == 1 && la[b] == 1 && ld[b] == exp_diva(0), "R3", "fast path write",
        ld[b], exp_diva(0));
    chk(!e, "R3", "fast path err", e, 0);
  endtask

  task automatic t_invalid;
    int b, n; logic e;
    request(2'd0, 3'd5, b, n, e);
    chk(n == 0 && e, "R8", "bad index", {n[7:0], e}, 9'h001);
    request(2'd3, 3'd1, b, n, e);
    chk(n == 0 && e, "R8", "reserved code", {n[7:0], e}, 9'h001);
  endtask

  task automatic t_timeout;
    int b, n, d; logic e; logic [31:0] g0 = cur_gen;
    no_lock = 1'b1;
    request(2'd0, 3'd0, b, n, e);
    check_full(b, n, 0, g0, 1'b0);
    chk(e, "R7", "timeout err", e, 1);
    d = done_t - lt[b+5];
    chk(d >= TO && d <= TO + 2, "R7", "timeout ticks", d, TO);
    chk(cur_gen[4], "R7", "bypass kept", cur_gen[4], 1);
    no_lock = 1'b0;
  endtask

  task automatic t_busy_ignore;
    int b, wd = 0; logic [31:0] g0 = cur_gen;
    b = nlog;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_idx = 3'd3;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req_ready && busy, "R10", "ready low when busy", req_ready, 0);
    req_valid = 1'b1; req_op = 2'd2;
    @(negedge clk); req_valid = 1'b0;
    while (!done && wd < 5000) begin @(negedge clk); wd++; end
    repeat (30) @(negedge clk);
    check_full(b, nlog - b, 3, g0, 1'b1);
    chk(!busy && ld[nlog-1][9], "R10", "dropped request left reset set",
        ld[nlog-1], 32'h2000_0200);
    cur_gen = ld[nlog-1];
  endtask

  task automatic t_power_down;
    int b, n; logic e;
    request(2'd2, 3'd0, b, n, e);
    chk(n == 1 && ld[b] == (cur_gen | 0) && !ld[b][9] && ld[b][29], "R9",
        "power-down write", ld[b], 32'h2000_0000);
    repeat (2) @(negedge clk);
    chk(!pll_lock && !e, "R9", "power-down lock", pll_lock, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_power_up;
    t_full(1);
    t_fast;
    t_full(2);
    t_invalid;
    t_timeout;
    t_busy_ignore;
    t_power_down;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule